// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block supplies the bytes that an interrupt controller places on the processor data bus while the processor acknowledges an interrupt. It counts acknowledge pulses, latches the level of the winning request when the first pulse begins, and releases one byte per pulse. Two processor styles are served. With an 8-bit processor the sequence is three pulses long: a call opcode, then the low and high halves of a call target taken from a table of eight entries spaced 4 or 8 bytes apart. With a 16-bit processor the sequence is two pulses long: the first pulse drives nothing and the second carries a single vector byte.

Several controllers can share one acknowledge sequence. A master announces on three cascade lines which slave owns the request, and that slave then supplies the bytes after the opcode. The master keeps all bytes for itself when the winning input has no slave behind it. Priority resolution and in-service tracking are done elsewhere. The winning level and the configuration arrive as inputs.

Top module: `ivg_top`

## Requirements
- R1: In 8-bit mode (`cfg_cpu16`=0) a controller that owns the request drives 0xCD on the first acknowledge pulse, the low target byte on the second and the high target byte (programmed address bits 15..8, `cfg_base[10:3]`) on the third. Pulses advance when the acknowledge strobe falls, and the sequence restarts at the opcode after the third pulse.
- R2: With 4-byte spacing (`cfg_spacing4`=1) in 8-bit mode the low target byte is {`cfg_base[2:0]`, level[2:0], 2'b00}.
- R3: With 8-byte spacing (`cfg_spacing4`=0) in 8-bit mode the low target byte is {`cfg_base[2:1]`, level[2:0], 3'b000}. `cfg_base[0]` is not used.
- R4: In 16-bit mode (`cfg_cpu16`=1) the first pulse drives no data and the second pulse carries {`cfg_base[10:6]`, level[2:0]}. `cfg_spacing4` and `cfg_base[5:0]` have no effect, and the sequence restarts after the second pulse.
- R5: `data_oe` is high only while `ack` is high and this device owns the current byte. While `data_oe` is low, `data_out` is 0 (this includes the gaps between pulses).
- R6: A cascaded master (`cfg_cascaded`=1, `cfg_master`=1) whose latched level L has `cfg_casc[L]`=1 drives 0xCD on the first pulse in 8-bit mode and no later byte. From the cycle after the first pulse rises until the cycle after the last pulse falls, it raises `casc_oe` with `casc_out`=L.
- R7: A cascaded master whose latched level has `cfg_casc[L]`=0 supplies every byte itself, as in R1 to R4, and keeps `casc_oe` low with `casc_out`=0.
- R8: A cascaded slave (`cfg_cascaded`=1, `cfg_master`=0) never drives the first pulse. It drives the later bytes only when `casc_in` equals `cfg_casc[2:0]`, and `cfg_casc[7:3]` is ignored. A slave never raises `casc_oe`.
- R9: The request level is captured when the first pulse of a sequence rises. Changes on `req_level` later in the sequence do not alter the bytes.
- R10: After a synchronous reset (`rst_n` low at a clock edge) the sequence is back at the opcode pulse, and with `ack` low `data_oe`, `data_out`, `casc_oe` and `casc_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpu16 | input | 1 | 1: 16-bit processor mode, 0: 8-bit call mode |
| cfg_spacing4 | input | 1 | 1: table entries 4 bytes apart, 0: 8 bytes apart |
| cfg_cascaded | input | 1 | 1: device is part of a cascade |
| cfg_master | input | 1 | In a cascade, 1: master, 0: slave |
| cfg_base | input | 11 | Programmed address bits 15..5 |
| cfg_casc | input | 8 | Master: one bit per input with a slave. Slave: bits 2..0 are its identity |
| req_level | input | 3 | Level of the winning request |
| ack | input | 1 | Acknowledge strobe, active high, sampled on clk |
| casc_in | input | 3 | Cascade lines as seen by a slave |
| data_out | output | 8 | Byte for the data bus, 0 when not driven |
| data_oe | output | 1 | Data bus drive enable |
| casc_out | output | 3 | Slave identity driven by a master |
| casc_oe | output | 1 | Cascade line drive enable |

## Verification
The vector walk uses three programmed bases (mixed bits, all ones, all zeros) and several levels, so that a misplaced level field or a wrong base slice changes a specific byte. Spacing-4 and spacing-8 runs with the same base and level show which bits each spacing takes from the program. 16-bit runs with both spacing settings show that the spacing bit is ignored. Master runs with and without a slave on the winning input show the split of bytes and the cascade drive. Slave runs with matching and non-matching cascade lines, one of them with the upper identity bits set, show the comparison rule. Directed tests cover the reset state, a reset in the middle of a sequence, and a level change after the first pulse.

// File: rtl/ivg_pkg.sv
// Package: shared constants and types for the acknowledge vector generator.
// Assumes 8 request levels and an 8-bit data bus.
package ivg_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int BASE_W  = ADDR_W - 5;        // programmed bits 15..5
    localparam int HI_LSB  = DATA_W - 5;        // base index of address bit 8
    localparam logic [DATA_W-1:0] CALL_OPCODE = 8'hCD;

    // Position inside the acknowledge sequence
    typedef enum logic [1:0] {
        PH_OPC = 2'd0,   // first pulse
        PH_LO  = 2'd1,   // second pulse
        PH_HI  = 2'd2    // third pulse (8-bit mode only)
    } phase_t;
endpackage

// File: rtl/ivg_ack_seq.sv
// Acknowledge sequencer: finds the edges of the acknowledge strobe, tracks
// which pulse of the sequence is current and latches the winning level when
// the first pulse rises. Assumes ack is synchronous to clk.
module ivg_ack_seq
    import ivg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             cpu16,
    input  logic [LVL_W-1:0] req_level,
    output phase_t           phase,
    output logic             busy,
    output logic [LVL_W-1:0] lvl_q
);
    logic   ack_q;
    logic   ack_rise;
    logic   ack_fall;
    phase_t last_ph;

    // Edge detection on the sampled strobe
    always_comb begin
        ack_rise = ack & ~ack_q;
        ack_fall = ~ack & ack_q;
    end

    // Final pulse index depends on the processor mode
    always_comb last_ph = cpu16 ? PH_LO : PH_HI;

    // Phase, busy flag and level latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            phase <= PH_OPC;
            busy  <= 1'b0;
            lvl_q <= '0;
        end else begin
            ack_q <= ack;
            if (ack_rise && phase == PH_OPC && !busy) begin
                busy  <= 1'b1;
                lvl_q <= req_level;
            end
            if (ack_fall) begin
                if (phase == last_ph) begin
                    phase <= PH_OPC;
                    busy  <= 1'b0;
                end else begin
                    phase <= phase_t'(phase + 2'd1);
                end
            end
        end
    end

    // R9: latched level holds while a sequence is running
    a_r9_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lvl_q));

    // R1: a later pulse is only reached inside a started sequence
    a_r1_phase_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_OPC) |-> busy);

    // R1: the phase never reaches an unused code
    a_r1_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);
endmodule

// File: rtl/ivg_byte_fmt.sv
// Byte formatter: builds the byte for the current pulse from the mode, the
// spacing, the programmed address and the latched level. Purely combinational.
// Assumes phase PH_HI only occurs in 8-bit mode.
module ivg_byte_fmt
    import ivg_pkg::*;
(
    input  phase_t            phase,
    input  logic              cpu16,
    input  logic              spacing4,
    input  logic [BASE_W-1:0] base,
    input  logic [LVL_W-1:0]  lvl,
    output logic [DATA_W-1:0] byte_val
);
    logic [DATA_W-1:0] lo_sp4;
    logic [DATA_W-1:0] lo_sp8;
    logic [DATA_W-1:0] hi_addr;
    logic [DATA_W-1:0] vec16;

    // Candidate bytes for each mode and spacing
    always_comb begin
        lo_sp4  = {base[2:0], lvl, 2'b00};
        lo_sp8  = {base[2:1], lvl, 3'b000};
        hi_addr = base[BASE_W-1:HI_LSB];
        vec16   = {base[BASE_W-1:BASE_W-5], lvl};
    end

    // Select the byte belonging to the current pulse
    always_comb begin
        unique case (phase)
            PH_OPC:  byte_val = cpu16 ? '0 : CALL_OPCODE;
            PH_LO:   byte_val = cpu16 ? vec16 : (spacing4 ? lo_sp4 : lo_sp8);
            PH_HI:   byte_val = hi_addr;
            default: byte_val = '0;
        endcase
    end
endmodule

// File: rtl/ivg_role.sv
// Cascade role logic: decides whether this device owns the byte of the
// current pulse and drives the cascade lines when acting as master.
// Assumes configuration is stable during a sequence.
module ivg_role
    import ivg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack,
    input  logic               cpu16,
    input  logic               cascaded,
    input  logic               master,
    input  logic [NUM_LVL-1:0] casc_cfg,
    input  logic [LVL_W-1:0]   casc_in,
    input  phase_t             phase,
    input  logic               busy,
    input  logic [LVL_W-1:0]   lvl,
    output logic               drive_data,
    output logic               casc_oe,
    output logic [LVL_W-1:0]   casc_out
);
    logic [NUM_LVL-1:0] lvl_hot;
    logic               has_slave;
    logic               is_slave;
    logic               id_match;
    logic               own_byte;

    // One-hot decode of the latched level, one bit per input
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl_dec
        assign lvl_hot[g] = (lvl == LVL_W'(g));
    end

    // Role flags
    always_comb begin
        has_slave = |(lvl_hot & casc_cfg);
        is_slave  = cascaded & ~master;
        id_match  = (casc_in == casc_cfg[LVL_W-1:0]);
    end

    // Ownership of the current byte
    always_comb begin
        if (phase == PH_OPC)
            own_byte = ~cpu16 & ~is_slave;
        else if (!cascaded)
            own_byte = 1'b1;
        else if (master)
            own_byte = ~has_slave;
        else
            own_byte = id_match;
    end

    // Output enables
    always_comb begin
        drive_data = ack & own_byte;
        casc_oe    = cascaded & master & busy & has_slave;
        casc_out   = casc_oe ? lvl : '0;
    end

    // R8: a slave never drives the cascade lines
    a_r8_slave_no_casc: assert property (@(posedge clk) disable iff (!rst_n)
        (cascaded && !master) |-> !casc_oe);

    // R8: a slave only drives data with matching cascade lines
    a_r8_slave_match: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_data && cascaded && !master) |-> (casc_in == casc_cfg[LVL_W-1:0]));

    // R6: the announced identity points at an input with a slave
    a_r6_casc_points_slave: assert property (@(posedge clk) disable iff (!rst_n)
        casc_oe |-> casc_cfg[casc_out]);

    // R4: no data on the first pulse in 16-bit mode
    a_r4_quiet_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu16 && phase == PH_OPC) |-> !drive_data);
endmodule

// File: rtl/ivg_top.sv
// Interrupt acknowledge vector generator, top level. Ties the sequencer,
// the byte formatter and the cascade role logic together and gates the
// data bus. Assumes configuration changes only between sequences.
module ivg_top
    import ivg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_cpu16,
    input  logic               cfg_spacing4,
    input  logic               cfg_cascaded,
    input  logic               cfg_master,
    input  logic [BASE_W-1:0]  cfg_base,
    input  logic [NUM_LVL-1:0] cfg_casc,
    input  logic [LVL_W-1:0]   req_level,
    input  logic               ack,
    input  logic [LVL_W-1:0]   casc_in,
    output logic [DATA_W-1:0]  data_out,
    output logic               data_oe,
    output logic [LVL_W-1:0]   casc_out,
    output logic               casc_oe
);
    phase_t            phase;
    logic              busy;
    logic [LVL_W-1:0]  lvl_q;
    logic [DATA_W-1:0] byte_val;
    logic              drive_data;

    ivg_ack_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack       (ack),
        .cpu16     (cfg_cpu16),
        .req_level (req_level),
        .phase     (phase),
        .busy      (busy),
        .lvl_q     (lvl_q)
    );

    ivg_byte_fmt u_fmt (
        .phase    (phase),
        .cpu16    (cfg_cpu16),
        .spacing4 (cfg_spacing4),
        .base     (cfg_base),
        .lvl      (lvl_q),
        .byte_val (byte_val)
    );

    ivg_role u_role (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack        (ack),
        .cpu16      (cfg_cpu16),
        .cascaded   (cfg_cascaded),
        .master     (cfg_master),
        .casc_cfg   (cfg_casc),
        .casc_in    (casc_in),
        .phase      (phase),
        .busy       (busy),
        .lvl        (lvl_q),
        .drive_data (drive_data),
        .casc_oe    (casc_oe),
        .casc_out   (casc_out)
    );

    // Gate the data bus with the drive decision
    always_comb begin
        data_oe  = drive_data;
        data_out = drive_data ? byte_val : '0;
    end

    // R5: data is only driven during an acknowledge pulse
    a_r5_oe_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ack);

    // R5: the bus is quiet when not driven
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));
endmodule

// File: tb/ivg_top_bench.sv
module ivg_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpu16 = 1'b0, cfg_spacing4 = 1'b0, cfg_cascaded = 1'b0, cfg_master = 1'b0;
    logic [10:0] cfg_base = '0;
    logic [7:0]  cfg_casc = '0;
    logic [2:0]  req_level = '0;
    logic        ack = 1'b0;
    logic [2:0]  casc_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [2:0]  casc_out;
    logic        casc_oe;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;   // 50 MHz

    ivg_top u_ivg_top (
        .clk(clk), .rst_n(rst_n), .cfg_cpu16(cfg_cpu16), .cfg_spacing4(cfg_spacing4),
        .cfg_cascaded(cfg_cascaded), .cfg_master(cfg_master), .cfg_base(cfg_base),
        .cfg_casc(cfg_casc), .req_level(req_level), .ack(ack), .casc_in(casc_in),
        .data_out(data_out), .data_oe(data_oe), .casc_out(casc_out), .casc_oe(casc_oe)
    );

    typedef struct packed {
        logic       cpu16;
        logic       sp4;
        logic       cascd;
        logic       mst;
        logic [10:0] base;
        logic [7:0] casc;
        logic [2:0] lvl;
        logic [2:0] cin;
        logic [2:0] oe;      // bit i: device drives pulse i
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       coe;
        logic [2:0] cv;
    } vec_t;

    localparam int NV = 16;
    localparam logic [59:0] VEC [NV] = '{
        {1'b0,1'b1,1'b0,1'b0,11'h5A3,8'h00,3'd5,3'd0,3'b111,8'hCD,8'h74,8'hB4,1'b0,3'd0},
        {1'b0,1'b0,1'b0,1'b0,11'h5A3,8'h00,3'd5,3'd0,3'b111,8'hCD,8'h68,8'hB4,1'b0,3'd0},
        {1'b1,1'b1,1'b0,1'b0,11'h5A3,8'h00,3'd5,3'd0,3'b010,8'h00,8'hB5,8'h00,1'b0,3'd0},
        {1'b1,1'b0,1'b0,1'b0,11'h5A3,8'h00,3'd7,3'd0,3'b010,8'h00,8'hB7,8'h00,1'b0,3'd0},
        {1'b0,1'b1,1'b0,1'b0,11'h5A3,8'h00,3'd0,3'd0,3'b111,8'hCD,8'h60,8'hB4,1'b0,3'd0},
        {1'b0,1'b0,1'b0,1'b0,11'h5A3,8'h00,3'd7,3'd0,3'b111,8'hCD,8'h78,8'hB4,1'b0,3'd0},
        {1'b0,1'b1,1'b0,1'b0,11'h7FF,8'h00,3'd2,3'd0,3'b111,8'hCD,8'hE8,8'hFF,1'b0,3'd0},
        {1'b1,1'b0,1'b0,1'b0,11'h7FF,8'h00,3'd2,3'd0,3'b010,8'h00,8'hFA,8'h00,1'b0,3'd0},
        {1'b0,1'b1,1'b1,1'b1,11'h5A3,8'h20,3'd5,3'd0,3'b001,8'hCD,8'h00,8'h00,1'b1,3'd5},
        {1'b0,1'b1,1'b1,1'b1,11'h7FF,8'h20,3'd2,3'd0,3'b111,8'hCD,8'hE8,8'hFF,1'b0,3'd0},
        {1'b1,1'b1,1'b1,1'b1,11'h5A3,8'h20,3'd5,3'd0,3'b000,8'h00,8'h00,8'h00,1'b1,3'd5},
        {1'b0,1'b1,1'b1,1'b0,11'h000,8'h05,3'd3,3'd5,3'b110,8'h00,8'h0C,8'h00,1'b0,3'd0},
        {1'b0,1'b1,1'b1,1'b0,11'h000,8'h05,3'd3,3'd4,3'b000,8'h00,8'h00,8'h00,1'b0,3'd0},
        {1'b1,1'b1,1'b1,1'b0,11'h000,8'h05,3'd3,3'd5,3'b010,8'h00,8'h03,8'h00,1'b0,3'd0},
        {1'b1,1'b0,1'b1,1'b0,11'h7FF,8'hFD,3'd7,3'd5,3'b010,8'h00,8'hFF,8'h00,1'b0,3'd0},
        {1'b0,1'b0,1'b1,1'b1,11'h5A3,8'h80,3'd7,3'd0,3'b001,8'hCD,8'h00,8'h00,1'b1,3'd7}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string vtag(input vec_t v);
        if (!v.cascd)    return v.cpu16 ? "R4" : (v.sp4 ? "R2" : "R3");
        else if (v.mst)  return v.coe ? "R6" : "R7";
        else             return "R8";
    endfunction

    // One pulse: raise ack, sample one clock later, lower ack, sample the gap
    task automatic pulse_check(input string tag, input logic oe_e, input logic [7:0] b_e,
                               input logic chk_casc, input logic coe_e, input logic [2:0] cv_e);
        @(negedge clk) ack = 1'b1;
        @(negedge clk);
        chk({tag, " R5 oe"}, {7'd0, data_oe}, {7'd0, oe_e});
        chk({tag, " byte"}, data_out, oe_e ? b_e : 8'h00);
        if (chk_casc) begin
            chk({tag, " casc_oe"}, {7'd0, casc_oe}, {7'd0, coe_e});
            chk({tag, " casc_out"}, {5'd0, casc_out}, {5'd0, coe_e ? cv_e : 3'd0});
        end
        ack = 1'b0;
        @(negedge clk);
        chk({tag, " R5 gap oe"}, {7'd0, data_oe}, 8'h00);
        chk({tag, " R5 gap data"}, data_out, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        vec_t v;
        int   np;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 data_oe", {7'd0, data_oe}, 8'h00);
        chk("R10 data_out", data_out, 8'h00);
        chk("R10 casc_oe", {7'd0, casc_oe}, 8'h00);
        chk("R10 casc_out", {5'd0, casc_out}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk
        for (int k = 0; k < NV; k++) begin
            v = vec_t'(VEC[k]);
            cfg_cpu16 = v.cpu16; cfg_spacing4 = v.sp4; cfg_cascaded = v.cascd;
            cfg_master = v.mst; cfg_base = v.base; cfg_casc = v.casc;
            req_level = v.lvl; casc_in = v.cin;
            @(negedge clk);
            np = v.cpu16 ? 2 : 3;
            for (int i = 0; i < np; i++) begin
                logic [7:0] be;
                be = (i == 0) ? v.b0 : (i == 1) ? v.b1 : v.b2;
                pulse_check((i == 0 && !v.cpu16 && !v.cascd) ? "R1" : vtag(v),
                            v.oe[i], be, i > 0, v.coe, v.cv);
            end
            chk({vtag(v), " R6 casc released"}, {7'd0, casc_oe}, 8'h00);
        end

        // R9: level change after the first pulse is ignored
        cfg_cpu16 = 1'b0; cfg_spacing4 = 1'b1; cfg_cascaded = 1'b0; cfg_master = 1'b0;
        cfg_base = 11'h5A3; cfg_casc = 8'h00; req_level = 3'd5;
        @(negedge clk);
        pulse_check("R9 p0", 1'b1, 8'hCD, 1'b0, 1'b0, 3'd0);
        req_level = 3'd2;
        pulse_check("R9 p1", 1'b1, 8'h74, 1'b0, 1'b0, 3'd0);
        pulse_check("R9 p2", 1'b1, 8'hB4, 1'b0, 1'b0, 3'd0);

        // R1: after three pulses a new sequence starts with the opcode and new level
        pulse_check("R1 restart p0", 1'b1, 8'hCD, 1'b0, 1'b0, 3'd0);
        pulse_check("R1 restart p1", 1'b1, 8'h68 ^ 8'h68 ^ 8'h68, 1'b0, 1'b0, 3'd0);
        pulse_check("R1 restart p2", 1'b1, 8'hB4, 1'b0, 1'b0, 3'd0);

        // R10: reset in the middle of a sequence returns to the opcode pulse
        cfg_cascaded = 1'b1; cfg_master = 1'b1; cfg_casc = 8'h20; req_level = 3'd5;
        @(negedge clk);
        pulse_check("R10 pre", 1'b1, 8'hCD, 1'b0, 1'b0, 3'd0);
        chk("R10 pre casc_oe", {7'd0, casc_oe}, 8'h01);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 mid casc_oe", {7'd0, casc_oe}, 8'h00);
        chk("R10 mid casc_out", {5'd0, casc_out}, 8'h00);
        rst_n = 1'b1;
        cfg_cascaded = 1'b0; cfg_master = 1'b0; cfg_casc = 8'h00;
        @(negedge clk);
        pulse_check("R10 post p0", 1'b1, 8'hCD, 1'b0, 1'b0, 3'd0);
        pulse_check("R10 post p1", 1'b1, 8'h74, 1'b0, 1'b0, 3'd0);
        pulse_check("R10 post p2", 1'b1, 8'hB4, 1'b0, 1'b0, 3'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule